// File: doc/BRIEF.md
# Block DMA Transfer Controller

This controller moves one block of words from a streaming device into main memory without help from the processor. A set-up port loads a start word address and a word count. The controller acknowledges a set-up it accepts and becomes busy. It refuses a set-up while a transfer is running, and it refuses a set-up whose count is zero.

Device words enter over a valid/ready handshake and are held in a small internal FIFO. This keeps device bursts apart from bus timing. While the FIFO holds data, the controller raises a bus request. In a cycle where the grant is also high, it writes the oldest buffered word to memory. It then drops the request for at least one cycle, so the bus is taken one word at a time. Each write moves the address up by one word and lowers the remaining count by one. After the last write, a one-cycle completion pulse is raised and the controller goes idle.

Top module: `blk_dma_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, cfg_ack, bus_req, mem_we, dev_ready and done are all 0.
- R2: A set-up (cfg_start high) taken while idle with a nonzero cfg_count gives cfg_ack = 1 for exactly the next cycle, and busy = 1 from that cycle on.
- R3: A set-up taken while busy, or with cfg_count = 0, is ignored: cfg_ack stays 0, and addresses, data and completion of the running transfer are unchanged.
- R4: dev_ready is 0 whenever the FIFO holds FIFO_DEPTH (= 2^FIFO_AW) accepted words that are not yet written.
- R5: bus_req is high only while busy and only when at least one accepted word is still unwritten. A memory write (mem_we = 1) happens only in a cycle where bus_gnt and bus_req are both high.
- R6: In the cycle after any memory write, bus_req is 0 (the bus is released after each word).
- R7: The k-th write (k = 0, 1, ...) of a transfer goes to mem_addr = start address + k and carries the k-th word accepted from the device.
- R8: Exactly cfg_count writes are made. done is a one-cycle pulse in the cycle after the last write, and busy is 0 in that cycle.
- R9: Once cfg_count words have been accepted in a transfer, dev_ready stays 0 until the transfer ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Set-up request strobe |
| cfg_addr | input | ADDR_W | Start word address of the block |
| cfg_count | input | CNT_W | Number of words in the block |
| cfg_ack | output | 1 | One-cycle acknowledge of an accepted set-up |
| busy | output | 1 | Transfer in progress |
| dev_valid | input | 1 | Device offers a word |
| dev_data | input | DATA_W | Device word |
| dev_ready | output | 1 | Controller accepts a device word this cycle |
| bus_req | output | 1 | Request for the memory bus |
| bus_gnt | input | 1 | Memory bus grant |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| done | output | 1 | One-cycle transfer-complete pulse |

## Verification
The hardest state to reach is a full FIFO. Reaching it needs the device to run ahead of the bus by FIFO_DEPTH words while the remaining count still allows more intake. The stimulus gets there by holding the grant low for the first dozen cycles of a transfer, while the device offers a word every cycle. Blocks longer than the FIFO then stall intake and resume it as words drain. Blocks of one to five words are swept across several device gap patterns and grant patterns. A set-up injected mid-transfer checks that the running block's addresses and data stay intact.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} phase_t;
endpackage

// File: rtl/dma_fifo.sv
module dma_fifo #(
  parameter int DATA_W = 16,
  parameter int AW     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              full,
  output logic              empty
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] store [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [AW:0]       fill;

  always_ff @(posedge clk) begin
    if (push) store[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign head  = store[rp];
  assign full  = (fill == (AW+1)'(DEPTH));
  assign empty = (fill == '0);
endmodule

// File: rtl/dma_intake.sv
module dma_intake #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_count,
  input  logic             active,
  input  logic             fifo_full,
  input  logic             dev_valid,
  output logic             dev_ready,
  output logic             push
);
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)       left <= '0;
    else if (load) left <= load_count;
    else if (push) left <= left - 1'b1;
  end

  assign dev_ready = active && !fifo_full && (left != '0);
  assign push      = dev_ready && dev_valid;
endmodule

// File: rtl/dma_writer.sv
module dma_writer #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [CNT_W-1:0]  load_count,
  input  logic              active,
  input  logic              fifo_empty,
  input  logic              bus_gnt,
  output logic              bus_req,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              last_wr,
  output logic              done
);
  logic [CNT_W-1:0] left;

  assign wr_en   = bus_req && bus_gnt;
  assign last_wr = wr_en && (left == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      left    <= '0;
      wr_addr <= '0;
      bus_req <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= last_wr;
      if (load) begin
        left    <= load_count;
        wr_addr <= load_addr;
        bus_req <= 1'b0;
      end else if (wr_en) begin
        left    <= left - 1'b1;
        wr_addr <= wr_addr + 1'b1;
        bus_req <= 1'b0;
      end else begin
        bus_req <= active && !fifo_empty;
      end
    end
  end
endmodule

// File: rtl/blk_dma_ctrl.sv
module blk_dma_ctrl #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 10,
  parameter int FIFO_AW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_start,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  output logic              cfg_ack,
  output logic              busy,
  input  logic              dev_valid,
  input  logic [DATA_W-1:0] dev_data,
  output logic              dev_ready,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              done
);
  import dma_pkg::*;

  phase_t phase;
  logic   start_ok, push, fifo_full, fifo_empty, last_wr;

  assign busy     = (phase == PH_RUN);
  assign start_ok = cfg_start && !busy && (cfg_count != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cfg_ack <= 1'b0;
    end else begin
      cfg_ack <= start_ok;
      if (start_ok)     phase <= PH_RUN;
      else if (last_wr) phase <= PH_IDLE;
    end
  end

  dma_intake #(.CNT_W(CNT_W)) u_intake (
    .clk(clk), .rst(rst), .load(start_ok), .load_count(cfg_count),
    .active(busy), .fifo_full(fifo_full), .dev_valid(dev_valid),
    .dev_ready(dev_ready), .push(push)
  );

  dma_fifo #(.DATA_W(DATA_W), .AW(FIFO_AW)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .push_data(dev_data),
    .pop(mem_we), .head(mem_wdata), .full(fifo_full), .empty(fifo_empty)
  );

  dma_writer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_writer (
    .clk(clk), .rst(rst), .load(start_ok), .load_addr(cfg_addr),
    .load_count(cfg_count), .active(busy), .fifo_empty(fifo_empty),
    .bus_gnt(bus_gnt), .bus_req(bus_req), .wr_en(mem_we),
    .wr_addr(mem_addr), .last_wr(last_wr), .done(done)
  );
endmodule

// File: rtl/blk_dma_ctrl_chk.sv
module blk_dma_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_start,
  input logic              cfg_ack,
  input logic              busy,
  input logic              dev_ready,
  input logic              fifo_full,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !cfg_ack && !bus_req && !done));
  a_r2_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    cfg_ack |=> !cfg_ack);
  a_r2_ack_busy: assert property (@(posedge clk) disable iff (rst)
    cfg_ack |-> busy);
  a_r3_no_ack_busy: assert property (@(posedge clk) disable iff (rst)
    (cfg_start && busy && !done) |=> !cfg_ack);
  a_r4_ready_not_full: assert property (@(posedge clk) disable iff (rst)
    dev_ready |-> !fifo_full);
  a_r5_req_busy: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> busy);
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !bus_req);
  a_r7_addr_step: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (mem_addr == $past(mem_addr) + 1'b1));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind blk_dma_ctrl blk_dma_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_ack(cfg_ack),
  .busy(busy), .dev_ready(dev_ready), .fifo_full(fifo_full),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_we(mem_we),
  .mem_addr(mem_addr), .done(done)
);

// File: tb/test_blk_dma_ctrl.sv
`timescale 1ns/1ps
module test_blk_dma_ctrl;
  localparam int ADDR_W = 16, DATA_W = 16, CNT_W = 10, FIFO_AW = 2;
  localparam int DEPTH = 1 << FIFO_AW;

  logic clk = 0, rst = 1;
  logic cfg_start = 0, dev_valid = 0, bus_gnt = 0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [CNT_W-1:0]  cfg_count = '0;
  logic [DATA_W-1:0] dev_data = '0;
  logic cfg_ack, busy, dev_ready, bus_req, mem_we, done;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;

  always #2 clk = ~clk;

  blk_dma_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .FIFO_AW(FIFO_AW))
  i_blk_dma_ctrl (
    .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_addr(cfg_addr),
    .cfg_count(cfg_count), .cfg_ack(cfg_ack), .busy(busy),
    .dev_valid(dev_valid), .dev_data(dev_data), .dev_ready(dev_ready),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done)
  );

  int n_tests = 0, n_fail = 0;
  int blk_addr, blk_cnt, pat, gpat, inject;
  int acc, wr, cyc;
  bit run = 0, exp_done = 0, seen_done = 0, prev_we = 0, inj_check = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] word_of(input int base, input int k);
    return DATA_W'(base * 3 + k * 37 + 5);
  endfunction

  always @(negedge clk) if (run && !seen_done) begin
    if (exp_done) begin
      chk(done == 1'b1, "R8 done pulse", int'(done), 1);
      chk(busy == 1'b0, "R8 idle after last", int'(busy), 0);
      chk(wr == blk_cnt, "R8 write count", wr, blk_cnt);
      dev_valid = 0; bus_gnt = 0; cfg_start = 0;
      exp_done = 0; seen_done = 1;
    end else begin
      if (done) chk(0, "R8 early done", 1, 0);
      if (inj_check) begin
        chk(cfg_ack == 1'b0, "R3 set-up while busy", int'(cfg_ack), 0);
        cfg_start = 0; inj_check = 0;
      end
      dev_valid = (acc < blk_cnt + 2) && (((cyc + acc) % (pat + 1)) == 0);
      dev_data  = word_of(blk_addr, acc);
      case (gpat)
        0: bus_gnt = 1;
        1: bus_gnt = (cyc % 3 == 2);
        default: bus_gnt = (cyc >= 12);
      endcase
      if (inject != 0 && cyc == 2) begin
        cfg_start = 1; cfg_addr = ADDR_W'(blk_addr ^ 16'h5555); cfg_count = 3;
        inj_check = 1;
      end
      #1;
      if (acc >= blk_cnt && dev_ready) chk(0, "R9 ready after full count", 1, 0);
      if (acc - wr == DEPTH && dev_ready) chk(0, "R4 ready with full FIFO", 1, 0);
      if (prev_we) chk(!bus_req, "R6 release after write", int'(bus_req), 0);
      if (bus_req) chk(busy && acc > wr, "R5 request without data", acc - wr, 1);
      if (dev_valid && dev_ready) acc++;
      if (mem_we) begin
        chk(bus_gnt == 1'b1, "R5 write without grant", int'(bus_gnt), 1);
        chk(mem_addr == ADDR_W'(blk_addr + wr), "R7 address",
            int'(mem_addr), int'(ADDR_W'(blk_addr + wr)));
        chk(mem_wdata == word_of(blk_addr, wr), "R7 data",
            int'(mem_wdata), int'(word_of(blk_addr, wr)));
        wr++;
        if (wr == blk_cnt) exp_done = 1;
      end
      prev_we = mem_we;
      cyc++;
    end
  end

  task automatic run_block(input int a, input int c, input int p, input int g, input int inj);
    @(negedge clk);
    cfg_start = 1; cfg_addr = ADDR_W'(a); cfg_count = CNT_W'(c);
    @(negedge clk);
    cfg_start = 0;
    chk(cfg_ack == 1'b1, "R2 ack", int'(cfg_ack), 1);
    chk(busy == 1'b1, "R2 busy", int'(busy), 1);
    blk_addr = a; blk_cnt = c; pat = p; gpat = g; inject = inj;
    acc = 0; wr = 0; cyc = 0; exp_done = 0; seen_done = 0; prev_we = 0;
    @(negedge clk);
    chk(cfg_ack == 1'b0, "R2 ack one cycle", int'(cfg_ack), 0);
    run = 1;
    wait (seen_done);
    run = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !cfg_ack && !bus_req && !mem_we && !dev_ready && !done,
        "R1 reset state", int'(busy | bus_req | dev_ready), 0);
    rst = 0;
    @(negedge clk);
    chk(!busy && !cfg_ack && !bus_req && !done, "R1 after reset", int'(busy), 0);
    // R3: zero count is refused
    cfg_start = 1; cfg_addr = 16'h0100; cfg_count = 0;
    @(negedge clk);
    cfg_start = 0;
    @(negedge clk);
    chk(cfg_ack == 1'b0, "R3 zero count ack", int'(cfg_ack), 0);
    chk(busy == 1'b0, "R3 zero count busy", int'(busy), 0);
    for (int c = 1; c <= 5; c++)
      for (int p = 0; p <= 1; p++)
        for (int g = 0; g <= 2; g++)
          run_block(16'h0200 + c * 64 + p * 16 + g, c, p, g, 0);
    run_block(16'hFFFC, 9, 0, 2, 0);
    run_block(16'h1234, 7, 0, 1, 1);
    run_block(16'h4000, 12, 1, 2, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule